// File: doc/BRIEF.md
# Private and shared credit allocator

This block hands out credits for a resource shared by several traffic classes, for example completion slots or DMA contexts. Every class owns a private reserve that only it can spend. It can also borrow from a common pool, but only when software has enabled borrowing for that class, and only up to a per-class borrowing cap. Each cycle one requester names a class and asks for a single credit. The block answers in the same cycle with a grant or a refusal, and it reports where the credit came from.

A release names a class and returns one credit. A borrowed credit goes back to the pool first, and a private credit goes back only after that. A release that finds the class holding nothing is refused and sets a sticky error flag. Software programs the limits and reads the usage counters through a small register port, with combinational reads and single-cycle writes.

Top module: `credit_pool_alloc`

## Requirements
- R1: After reset all limits, enables and counters read zero, `rel_err` is low and every request is refused.
- R2: A request is granted from the class's private reserve (`req_grant`=1, `req_pool`=0) whenever its private used count is below its private limit.
- R3: A class whose borrow-enable bit is 0 never receives a pool credit.
- R4: A class never holds more pool credits than its borrow cap.
- R5: A pool credit is granted only while the pool used count is below the pool total.
- R6: A request that satisfies none of the rules above is refused and changes no counter.
- R7: A release returns a held pool credit, lowering both the class's pool-held count and the pool used count, before it returns any private credit.
- R8: A release on a class that holds no credit changes no counter and sets `rel_err`. The flag stays set until a write to the status register with data bit 0 equal to 1.
- R9: When an allocation and a release occur in the same cycle, both are judged on the state before the clock edge and both take effect, on the same class or on different classes.
- R10: Register address = {sel[2:0], class}. The sel codes are: 0 private limit (RW), 1 borrow cap (RW), 2 borrow enable in bit 0 (RW), 3 class total used = private + pool-held (RO), 4 class pool-held (RO), 5 pool total (RW, class ignored), 6 pool used (RO), 7 status with `rel_err` in bit 0 (a write of 1 clears it).
- R11: No counter ever wraps below zero or past its limit, and the pool used count always equals the sum of the pool-held counts of all classes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Allocation request |
| req_cls | input | CLSW | Class of the request |
| req_grant | output | 1 | Request granted this cycle |
| req_pool | output | 1 | Granted credit came from the pool |
| rel_valid | input | 1 | Release of one credit |
| rel_cls | input | CLSW | Class of the release |
| rel_err | output | 1 | Sticky illegal-release flag |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | CLSW+3 | Register address {sel, class} |
| cfg_wdata | input | CW | Register write data |
| cfg_rdata | output | CW+1 | Register read data, combinational |

## Verification
A directed sequence walks one class through its private reserve, then its pool cap, and then into refusal, which shows whether private credits are spent first and where the cap applies. A second class has borrowing disabled, which separates the enable check from the cap check. Releases on a class that holds both kinds of credit show the return order, and a release on an empty class checks the sticky error and its clear. Long random runs with small limits then mix allocations, releases on the same and on different classes, and limit rewrites, so that the pool-exhaustion and simultaneous-update cases are hit many times.

// File: rtl/credit_pool_alloc.sv
module credit_pool_alloc #(
  parameter int CLSW = 2,
  parameter int CW   = 8,
  localparam int NCLS = 1 << CLSW,
  localparam int AW   = CLSW + 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  input  logic [CLSW-1:0] req_cls,
  output logic            req_grant,
  output logic            req_pool,
  input  logic            rel_valid,
  input  logic [CLSW-1:0] rel_cls,
  output logic            rel_err,
  input  logic            cfg_we,
  input  logic [AW-1:0]   cfg_addr,
  input  logic [CW-1:0]   cfg_wdata,
  output logic [CW:0]     cfg_rdata
);
  logic [NCLS-1:0][CW-1:0] priv_lim, com_cap, priv_used, com_held, pu_n, ch_n;
  logic [NCLS-1:0]         com_en;
  logic [CW-1:0]           pool_total, pool_used;
  logic                    err_q;

  logic priv_ok, com_ok, take_priv, rel_com, rel_priv, rel_bad;
  logic [2:0]      sel;
  logic [CLSW-1:0] idx;

  assign priv_ok   = priv_used[req_cls] < priv_lim[req_cls];
  assign com_ok    = com_en[req_cls] && (com_held[req_cls] < com_cap[req_cls])
                     && (pool_used < pool_total);
  assign req_grant = req_valid && (priv_ok || com_ok);
  assign req_pool  = req_grant && !priv_ok;
  assign take_priv = req_grant && priv_ok;

  assign rel_com  = rel_valid && (com_held[rel_cls] != '0);
  assign rel_priv = rel_valid && !rel_com && (priv_used[rel_cls] != '0);
  assign rel_bad  = rel_valid && !rel_com && !rel_priv;

  assign sel     = cfg_addr[AW-1:CLSW];
  assign idx     = cfg_addr[CLSW-1:0];
  assign rel_err = err_q;

  always_comb begin
    for (int i = 0; i < NCLS; i++) begin
      pu_n[i] = priv_used[i];
      ch_n[i] = com_held[i];
      if (take_priv && req_cls == CLSW'(i)) pu_n[i] = pu_n[i] + CW'(1);
      if (req_pool  && req_cls == CLSW'(i)) ch_n[i] = ch_n[i] + CW'(1);
      if (rel_priv  && rel_cls == CLSW'(i)) pu_n[i] = pu_n[i] - CW'(1);
      if (rel_com   && rel_cls == CLSW'(i)) ch_n[i] = ch_n[i] - CW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      priv_lim   <= '0;
      com_cap    <= '0;
      com_en     <= '0;
      priv_used  <= '0;
      com_held   <= '0;
      pool_total <= '0;
      pool_used  <= '0;
      err_q      <= 1'b0;
    end else begin
      priv_used <= pu_n;
      com_held  <= ch_n;
      pool_used <= pool_used + CW'(req_pool) - CW'(rel_com);
      if (cfg_we) begin
        case (sel)
          3'd0: priv_lim[idx] <= cfg_wdata;
          3'd1: com_cap[idx]  <= cfg_wdata;
          3'd2: com_en[idx]   <= cfg_wdata[0];
          3'd5: pool_total    <= cfg_wdata;
          default: ;
        endcase
      end
      if (rel_bad) err_q <= 1'b1;
      else if (cfg_we && sel == 3'd7 && cfg_wdata[0]) err_q <= 1'b0;
    end
  end

  always_comb begin
    case (sel)
      3'd0:    cfg_rdata = {1'b0, priv_lim[idx]};
      3'd1:    cfg_rdata = {1'b0, com_cap[idx]};
      3'd2:    cfg_rdata = (CW+1)'(com_en[idx]);
      3'd3:    cfg_rdata = {1'b0, priv_used[idx]} + {1'b0, com_held[idx]};
      3'd4:    cfg_rdata = {1'b0, com_held[idx]};
      3'd5:    cfg_rdata = {1'b0, pool_total};
      3'd6:    cfg_rdata = {1'b0, pool_used};
      default: cfg_rdata = (CW+1)'(err_q);
    endcase
  end
endmodule

// File: rtl/credit_pool_alloc_chk.sv
module credit_pool_alloc_chk #(
  parameter int CLSW = 2,
  parameter int CW   = 8,
  localparam int NCLS = 1 << CLSW,
  localparam int AW   = CLSW + 3
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    req_valid,
  input logic [CLSW-1:0]         req_cls,
  input logic                    cfg_we,
  input logic [AW-1:0]           cfg_addr,
  input logic [CW-1:0]           cfg_wdata,
  input logic                    rel_err,
  input logic [NCLS-1:0]         com_en,
  input logic [NCLS-1:0][CW-1:0] com_cap,
  input logic [NCLS-1:0][CW-1:0] com_held,
  input logic [CW-1:0]           pool_used,
  input logic [CW-1:0]           pool_total
);
  logic [CW+CLSW-1:0] held_sum;
  always_comb begin
    held_sum = '0;
    for (int i = 0; i < NCLS; i++) held_sum = held_sum + (CW+CLSW)'(com_held[i]);
  end

  a_r3_disabled_no_borrow: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !com_en[req_cls]) |=> com_held[$past(req_cls)] <= $past(com_held[req_cls]));

  a_r4_cap_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && com_held[req_cls] >= com_cap[req_cls])
      |=> com_held[$past(req_cls)] <= $past(com_held[req_cls]));

  a_r5_pool_no_growth_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    (pool_used >= pool_total) |=> pool_used <= $past(pool_used));

  a_r8_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (rel_err && !(cfg_we && cfg_addr[AW-1:CLSW] == 3'd7 && cfg_wdata[0])) |=> rel_err);

  a_r11_pool_matches_classes: assert property (@(posedge clk) disable iff (!rst_n)
    (CW+CLSW)'(pool_used) == held_sum);
endmodule

bind credit_pool_alloc credit_pool_alloc_chk #(.CLSW(CLSW), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_cls(req_cls),
  .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .rel_err(rel_err),
  .com_en(com_en), .com_cap(com_cap), .com_held(com_held),
  .pool_used(pool_used), .pool_total(pool_total)
);

// File: tb/credit_pool_alloc_bench.sv
module credit_pool_alloc_bench;
  localparam int CLSW = 2;
  localparam int CW   = 8;
  localparam int NCLS = 1 << CLSW;
  localparam int AW   = CLSW + 3;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, rel_valid = 0, cfg_we = 0;
  logic [CLSW-1:0] req_cls = '0, rel_cls = '0;
  logic [AW-1:0] cfg_addr = '0;
  logic [CW-1:0] cfg_wdata = '0;
  logic req_grant, req_pool, rel_err;
  logic [CW:0] cfg_rdata;

  credit_pool_alloc #(.CLSW(CLSW), .CW(CW)) u_credit_pool_alloc (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_cls(req_cls),
    .req_grant(req_grant), .req_pool(req_pool), .rel_valid(rel_valid),
    .rel_cls(rel_cls), .rel_err(rel_err), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata));

  always #10 clk = ~clk;

  int checks = 0, errors = 0;
  int m_plim[NCLS], m_cap[NCLS], m_en[NCLS], m_pu[NCLS], m_ch[NCLS];
  int m_ptot = 0, m_pused = 0, m_err = 0;

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int pred(int c);   // 0 refuse, 1 private, 2 pool
    if (m_pu[c] < m_plim[c]) return 1;
    if (m_en[c] != 0 && m_ch[c] < m_cap[c] && m_pused < m_ptot) return 2;
    return 0;
  endfunction

  task automatic cyc(bit av, int ac, bit rv, int rc, bit we, int sel, int wc, int wd);
    int p, rk;
    @(negedge clk);
    req_valid = av; req_cls = CLSW'(ac); rel_valid = rv; rel_cls = CLSW'(rc);
    cfg_we = we; cfg_addr = {3'(sel), CLSW'(wc)}; cfg_wdata = CW'(wd);
    #1;
    p = av ? pred(ac) : 0;
    if (av) begin
      chk("R2/R3/R4/R5/R6 grant", int'(req_grant), int'(p != 0));
      chk("R2 pool flag", int'(req_pool), int'(p == 2));
    end
    rk = 0;
    if (rv) rk = (m_ch[rc] != 0) ? 2 : (m_pu[rc] != 0) ? 1 : 3;
    @(posedge clk);
    if (p == 1) m_pu[ac]++;
    if (p == 2) begin m_ch[ac]++; m_pused++; end
    if (rk == 2) begin m_ch[rc]--; m_pused--; end
    if (rk == 1) m_pu[rc]--;
    if (we) begin
      case (sel)
        0: m_plim[wc] = wd;
        1: m_cap[wc]  = wd;
        2: m_en[wc]   = wd & 1;
        5: m_ptot     = wd;
        default: ;
      endcase
    end
    if (rk == 3) m_err = 1;
    else if (we && sel == 7 && (wd & 1) != 0) m_err = 0;
  endtask

  task automatic rd(int sel, int c, int exp, string req);
    @(negedge clk);
    req_valid = 0; rel_valid = 0; cfg_we = 0; cfg_addr = {3'(sel), CLSW'(c)};
    #1 chk(req, int'(cfg_rdata), exp);
  endtask

  task automatic check_all();
    for (int c = 0; c < NCLS; c++) begin
      rd(3, c, m_pu[c] + m_ch[c], "R10/R11 class used");
      rd(4, c, m_ch[c], "R7/R11 class pool-held");
    end
    rd(6, 0, m_pused, "R11 pool used");
    rd(7, 0, m_err, "R8 status");
    chk("R8 rel_err pin", int'(rel_err), m_err);
  endtask

  initial begin
    #4_000_000;
    errors++; checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(1234));
    for (int c = 0; c < NCLS; c++) begin
      m_plim[c] = 0; m_cap[c] = 0; m_en[c] = 0; m_pu[c] = 0; m_ch[c] = 0;
    end
    repeat (3) @(posedge clk);
    rst_n = 1;
    // R1: reset state
    for (int c = 0; c < NCLS; c++) rd(0, c, 0, "R1 private limit");
    rd(5, 0, 0, "R1 pool total");
    check_all();
    cyc(1, 2, 0, 0, 0, 0, 0, 0);  // R1 request refused after reset
    // configure class0: priv 2, cap 1, enabled; class1: priv 1, disabled; pool 3
    cyc(0, 0, 0, 0, 1, 0, 0, 2);
    cyc(0, 0, 0, 0, 1, 1, 0, 1);
    cyc(0, 0, 0, 0, 1, 2, 0, 1);
    cyc(0, 0, 0, 0, 1, 0, 1, 1);
    cyc(0, 0, 0, 0, 1, 1, 1, 3);
    cyc(0, 0, 0, 0, 1, 5, 0, 3);
    rd(1, 1, 3, "R10 cap readback");
    rd(2, 0, 1, "R10 enable readback");
    // R2 then R4: private, private, pool, refused at cap
    cyc(1, 0, 0, 0, 0, 0, 0, 0);
    cyc(1, 0, 0, 0, 0, 0, 0, 0);
    cyc(1, 0, 0, 0, 0, 0, 0, 0);
    cyc(1, 0, 0, 0, 0, 0, 0, 0);
    check_all();
    // R3: class1 disabled, second request refused
    cyc(1, 1, 0, 0, 0, 0, 0, 0);
    cyc(1, 1, 0, 0, 0, 0, 0, 0);
    check_all();
    // R7: release on class0 returns pool credit first
    cyc(0, 0, 1, 0, 0, 0, 0, 0);
    rd(4, 0, 0, "R7 pool credit returned first");
    rd(3, 0, 2, "R7 private kept");
    // R9: alloc + release same class, same cycle
    cyc(1, 0, 1, 0, 0, 0, 0, 0);
    check_all();
    // R8: illegal release on empty class 3, sticky, then clear
    cyc(0, 0, 1, 3, 0, 0, 0, 0);
    check_all();
    cyc(0, 0, 0, 0, 0, 0, 0, 0);
    check_all();
    cyc(0, 0, 0, 0, 1, 7, 0, 1);
    check_all();
    // R5: pool of 1 shared; class2 enabled with no private reserve
    cyc(0, 0, 0, 0, 1, 2, 2, 1);
    cyc(0, 0, 0, 0, 1, 1, 2, 5);
    cyc(0, 0, 0, 0, 1, 5, 0, 1);
    cyc(1, 2, 0, 0, 0, 0, 0, 0);
    cyc(1, 2, 0, 0, 0, 0, 0, 0);
    check_all();
    // random mix (R9, R11 and all policies)
    for (int n = 0; n < 3000; n++) begin
      bit av, rv, we;
      int sel;
      av = ($urandom % 3) != 0;
      rv = ($urandom % 3) == 0;
      we = ($urandom % 12) == 0;
      case ($urandom % 4)
        0: sel = 0; 1: sel = 1; 2: sel = 2; default: sel = 5;
      endcase
      if (we && ($urandom % 10) == 0) sel = 7;
      cyc(av, int'($urandom % NCLS), rv, int'($urandom % NCLS), we, sel,
          int'($urandom % NCLS), int'($urandom % 6));
      if (n % 16 == 15) check_all();
    end
    check_all();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule